// File: doc/BRIEF.md
# VGA Test-Pattern Mode Controller

This block produces 640x480 video timing from a 25 MHz pixel clock and, for each pixel, three 8-bit colour codes meant for external digital-to-analog converters. While reset is held, the block samples an 8-bit mode word from its byte input. That word selects a pattern generator and stays fixed until the next reset. One mode is a live pass-through: the byte input drives all three channels on every cycle. A second mode draws a horizontal ramp. A third alternates between full-scale and zero on neighbouring pixels, which gives the largest possible transition rate for measuring converter slew.

Beside the colour codes, the block drives active-low horizontal and vertical sync. It also drives horizontal and vertical blanking flags on two pins of a bidirectional port, with the output enables for those two pins set. A digital output byte carries both syncs and the top two bits of each colour in the pin order that a common two-bit-per-channel VGA adapter expects. Every output is registered, so sync, blanking and colour all change on the same clock edge.

Top module: `vga_pattern_ctrl`

## Requirements
- R1: The mode register loads the byte input on every clock edge while rst_ni is low. After rst_ni goes high it holds, and later changes on the byte input do not change the mode. Only pass-through mode reads the byte input afterwards.
- R2: In mode 0x00, every visible pixel shows the byte input value that was present at the clock edge producing it, on all three channels.
- R3: In mode 0x13, every visible pixel at column x shows floor(x*256/H_VIS) on all three channels. The ramp restarts at zero on each line.
- R4: In mode 0x21, every visible pixel in an even column shows 0x00 and every visible pixel in an odd column shows 0xFF, on all three channels.
- R5: Any other mode value shows 0x80 on all three channels at every visible pixel, and sync runs normally.
- R6: A line is H_VIS+H_FP+H_SYNC+H_BP clocks long. Horizontal sync is low exactly for columns H_VIS+H_FP through H_VIS+H_FP+H_SYNC-1.
- R7: A frame is V_VIS+V_FP+V_SYNC+V_BP lines long. Vertical sync is low exactly for lines V_VIS+V_FP through V_VIS+V_FP+V_SYNC-1.
- R8: The horizontal blank flag is 1 for columns at or beyond H_VIS. The vertical blank flag is 1 for lines at or beyond V_VIS. All colour codes are 0 whenever either flag is 1.
- R9: The digital byte has, from bit 0 to bit 7: red[7], green[7], blue[7], vsync, red[6], green[6], blue[6], hsync.
- R10: The bidirectional output has vertical blank on bit 0, horizontal blank on bit 1, and zeros on bits 7..2. The output enable is 0x03.
- R11: While rst_ni is low, the colours are 0, both syncs are high and both blank flags are 1. The first edge after release outputs column 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset; mode is sampled while low |
| ui_i | input | 8 | Mode word during reset, live pixel byte afterwards |
| uo_o | output | 8 | Packed syncs and colour high bits for a digital adapter |
| uio_o | output | 8 | Blank flags on bits 1:0 |
| uio_oe_o | output | 8 | Output enables for the bidirectional port |
| red_o | output | 8 | Red code |
| grn_o | output | 8 | Green code |
| blu_o | output | 8 | Blue code |

## Verification
The bench reduces the timing to a 16-column visible area inside a 24-clock line, and a 6-line visible area inside an 11-line frame. Each mode run therefore covers every porch, both sync pulses, the wrap at the end of each line and the wrap at the end of the frame, in a few hundred cycles. Because the visible width is 16, the ramp formula gives exact multiples of 16. The odd-column pattern hits both parities on every line, and a mid-run reset can be checked against a whole pass over the frame.

// File: rtl/vga_pat_pkg.sv
package vga_pat_pkg;
  localparam int CW = 8;

  typedef enum logic [7:0] {
    MODE_PASS = 8'h00,
    MODE_RAMP = 8'h13,
    MODE_ALT  = 8'h21
  } mode_e;

  localparam logic [CW-1:0] GREY = 8'h80;

  typedef struct packed {
    logic [CW-1:0] r;
    logic [CW-1:0] g;
    logic [CW-1:0] b;
  } rgb_t;
endpackage

// File: rtl/vga_timing.sv
module vga_timing #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int XW    = $clog2(H_TOT),
  localparam int YW    = $clog2(V_TOT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [XW-1:0] x_o,
  output logic          h_blank_o,
  output logic          v_blank_o,
  output logic          hs_n_o,
  output logic          vs_n_o
);
  localparam logic [XW-1:0] H_LAST = XW'(H_TOT - 1);
  localparam logic [XW-1:0] H_VE   = XW'(H_VIS);
  localparam logic [XW-1:0] H_SS   = XW'(H_VIS + H_FP);
  localparam logic [XW-1:0] H_SE   = XW'(H_VIS + H_FP + H_SYNC);
  localparam logic [YW-1:0] V_LAST = YW'(V_TOT - 1);
  localparam logic [YW-1:0] V_VE   = YW'(V_VIS);
  localparam logic [YW-1:0] V_SS   = YW'(V_VIS + V_FP);
  localparam logic [YW-1:0] V_SE   = YW'(V_VIS + V_FP + V_SYNC);

  logic [XW-1:0] h_cnt;
  logic [YW-1:0] v_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else if (h_cnt == H_LAST) begin
      h_cnt <= '0;
      v_cnt <= (v_cnt == V_LAST) ? '0 : v_cnt + 1'b1;
    end else begin
      h_cnt <= h_cnt + 1'b1;
    end
  end

  assign x_o       = h_cnt;
  assign h_blank_o = (h_cnt >= H_VE);
  assign v_blank_o = (v_cnt >= V_VE);
  assign hs_n_o    = !((h_cnt >= H_SS) && (h_cnt < H_SE));
  assign vs_n_o    = !((v_cnt >= V_SS) && (v_cnt < V_SE));

  p_hwrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_cnt == H_LAST) |=> (h_cnt == '0));
  p_vhold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_cnt != H_LAST) |=> $stable(v_cnt));
endmodule

// File: rtl/vga_pattern.sv
module vga_pattern
  import vga_pat_pkg::*;
#(
  parameter int H_VIS = 640,
  parameter int XW    = 10
) (
  input  logic [7:0]    mode_i,
  input  logic [XW-1:0] x_i,
  input  logic [7:0]    live_i,
  output rgb_t          pix_o
);
  localparam logic [XW+7:0] HV_W = (XW+8)'(H_VIS);

  logic [XW+7:0] num;
  logic [CW-1:0] ramp;
  logic [CW-1:0] lvl;

  assign num  = {x_i, 8'h00};
  assign ramp = CW'(num / HV_W);

  always_comb begin
    unique case (mode_i)
      MODE_PASS: lvl = live_i;
      MODE_RAMP: lvl = ramp;
      MODE_ALT:  lvl = x_i[0] ? 8'hFF : 8'h00;
      default:   lvl = GREY;
    endcase
    pix_o = '{r: lvl, g: lvl, b: lvl};
  end
endmodule

// File: rtl/vga_pattern_ctrl.sv
module vga_pattern_ctrl
  import vga_pat_pkg::*;
#(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] ui_i,
  output logic [7:0] uo_o,
  output logic [7:0] uio_o,
  output logic [7:0] uio_oe_o,
  output logic [7:0] red_o,
  output logic [7:0] grn_o,
  output logic [7:0] blu_o
);
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int XW    = $clog2(H_TOT);

  logic [7:0]    mode_q;
  logic [XW-1:0] x;
  logic          hb, vb, hs_n, vs_n;
  rgb_t          pix, pix_q;
  logic          hb_q, vb_q, hs_q, vs_q;

  // mode sampled synchronously while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= ui_i;
  end

  vga_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_timing (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .x_o       (x),
    .h_blank_o (hb),
    .v_blank_o (vb),
    .hs_n_o    (hs_n),
    .vs_n_o    (vs_n)
  );

  vga_pattern #(.H_VIS(H_VIS), .XW(XW)) u_pattern (
    .mode_i (mode_q),
    .x_i    (x),
    .live_i (ui_i),
    .pix_o  (pix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q <= '0;
      hb_q  <= 1'b1;
      vb_q  <= 1'b1;
      hs_q  <= 1'b1;
      vs_q  <= 1'b1;
    end else begin
      pix_q <= (hb || vb) ? '0 : pix;
      hb_q  <= hb;
      vb_q  <= vb;
      hs_q  <= hs_n;
      vs_q  <= vs_n;
    end
  end

  assign red_o    = pix_q.r;
  assign grn_o    = pix_q.g;
  assign blu_o    = pix_q.b;
  assign uo_o     = {hs_q, pix_q.b[6], pix_q.g[6], pix_q.r[6],
                     vs_q, pix_q.b[7], pix_q.g[7], pix_q.r[7]};
  assign uio_o    = {6'b0, hb_q, vb_q};
  assign uio_oe_o = 8'h03;

  p_mode_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> $stable(mode_q));
  p_blank_black_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hb_q || vb_q) |-> (pix_q == '0));
  p_hsync_in_blank_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hs_q |-> hb_q);
  p_vsync_in_blank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vs_q |-> vb_q);
endmodule

// File: tb/vga_pattern_ctrl_test.sv
`timescale 1ns/1ps
module vga_pattern_ctrl_test;
  localparam int HV = 16, HF = 2, HS = 3, HBK = 3;
  localparam int VV = 6,  VF = 1, VS = 2, VBK = 2;
  localparam int HT = HV + HF + HS + HBK;
  localparam int VT = VV + VF + VS + VBK;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] ui_i = 8'h00;
  logic [7:0] uo_o, uio_o, uio_oe_o, red_o, grn_o, blu_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  vga_pattern_ctrl #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HBK),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VBK)
  ) uut (.*);

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cycles++;

  initial begin
    wait (cycles > 20000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_col(logic [7:0] m, int x, int y, logic [7:0] live);
    if (x >= HV || y >= VV) return 8'h00;           // R8
    case (m)
      8'h00: return live;                            // R2
      8'h13: return 8'((x * 256) / HV);              // R3
      8'h21: return (x % 2 == 1) ? 8'hFF : 8'h00;    // R4
      default: return 8'h80;                         // R5
    endcase
  endfunction

  task automatic check_reset();
    chk("R11 red", red_o, 0);
    chk("R11 uo", uo_o, 8'h88);
    chk("R11 uio", uio_o, 8'h03);
  endtask

  task automatic run_mode(input logic [7:0] m, input int n);
    int pos = 0;
    rst_ni = 1'b0;
    ui_i = m;
    repeat (3) @(negedge clk_i);
    check_reset();
    rst_ni = 1'b1;
    for (int i = 0; i < n; i++) begin
      logic [7:0] live;
      int x, y;
      logic [7:0] c;
      logic hs, vs, hb, vb;
      live = 8'($urandom);
      if (i < 4) live = (i % 2 == 0) ? 8'h00 : 8'hFF;  // directed extremes
      ui_i = live;
      @(posedge clk_i);
      @(negedge clk_i);
      x = pos % HT;
      y = (pos / HT) % VT;
      c = exp_col(m, x, y, live);
      hs = !(x >= HV + HF && x < HV + HF + HS);       // R6
      vs = !(y >= VV + VF && y < VV + VF + VS);       // R7
      hb = (x >= HV);
      vb = (y >= VV);
      chk($sformatf("R1/R2-R5 mode %0h red x%0d y%0d", m, x, y), red_o, c);
      chk("R2-R5 grn", grn_o, c);
      chk("R2-R5 blu", blu_o, c);
      chk("R6/R7/R9 uo", uo_o, {hs, c[6], c[6], c[6], vs, c[7], c[7], c[7]});
      chk("R8/R10 uio", uio_o, {6'b0, hb, vb});
      chk("R10 oe", uio_oe_o, 8'h03);
      pos++;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R11 reset state
    repeat (2) @(negedge clk_i);
    check_reset();
    run_mode(8'h00, 300);            // R2 pass-through
    run_mode(8'h13, 300);            // R3, R1 live input ignored
    run_mode(8'h21, 300);            // R4
    run_mode(8'h5A, 280);            // R5
    for (int k = 0; k < 3; k++) begin
      logic [7:0] m;
      m = 8'($urandom);
      if (m == 8'h00 || m == 8'h13 || m == 8'h21) m = 8'h40;
      run_mode(m, 60);               // R5 random unknown modes
    end
    run_mode(8'h13, 40);             // R1 mid-frame reset restarts at 0,0 (R11)
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule